// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Aggregation

This peripheral holds two independent countdown channels behind a 32-bit word-only register bus. Each channel keeps a divisor (reload value) register, a control register and a read-only current-count register. A control write picks one of three operations (load the counter from the divisor, hold it, or let it run) and a tick source. Tick sources are modelled as enable inputs sampled on the system clock: four internal rate enables and one external tick. While running, a channel decrements once per selected tick. When it expires, it reloads from its latched limit and raises an expiry event.

Expiry events set per-channel bits in a shared status register. Software enables bits through a mask register and clears them through an acknowledge register: each write clears the bits it names and leaves nothing behind. A single level interrupt output is high whenever any status bit that is enabled in the mask is set. A free-running time counter that advances every clock cycle can also be read.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both channels are stopped with count 0, and status, mask, masked status and `irq` are all 0. Ticks on any line leave the counts at 0.
- R2: Writing a divisor register does not change the channel's count. A control write with operation field bits [1:0] = 0 (load) copies the current divisor into the count and latches it as the reload limit. Every legal control write latches the limit.
- R3: With operation 2 (run), the count drops by one in each cycle in which the selected tick input is high, and stays unchanged in cycles without that tick.
- R4: A running channel whose count is 0 or 1 when its tick arrives reloads the latched limit and sets its status bit in the same clock edge: channel 0 sets bit 0 and channel 1 sets bit 1. A limit of D (D >= 1) gives one expiry every D ticks.
- R5: Operation 1 (hold) stops the channel. Its count stays frozen while ticks arrive.
- R6: Control bits [4:2] select the tick source: codes 4, 5, 6 and 7 pick `tick_src[0]` to `tick_src[3]`, and codes 0 and 1 pick `ext_tick`. Codes 2 and 3 are illegal.
- R7: A control write with operation 3 or an illegal source code is ignored entirely: the count, run state, source and limit are kept, and a running channel goes on counting.
- R8: The mask register (0x48) reads back what was written. The masked status (0x54) reads status AND mask, and `irq` is high exactly when that value is nonzero.
- R9: A write to the acknowledge register (0x4C) clears every status bit whose written bit is 1. The value does not persist, so a later expiry sets its bit again.
- R10: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set. Other acknowledged bits are still cleared.
- R11: The time register (0x38) advances by exactly one per clock cycle.
- R12: Byte-address map: channel 0 divisor 0x00, count 0x04, control 0x08; channel 1 at 0x10, 0x14, 0x18; raw status 0x50. Unmapped addresses, and addresses with bits [1:0] not zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_src | input | 4 | Internal tick-rate enables, one per source code 4..7 |
| ext_tick | input | 1 | External tick enable, source codes 0 and 1 |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
The tick-source sweep tries all eight source codes against each of the five tick lines. This separates a correct source decode from one that counts on the wrong line, counts on every line, or accepts codes 2 and 3. Divisors 0 through 5 run on both channels, with the status bit read one tick before and at expiry; this shows an off-by-one period and a status bit landing on the wrong channel. All 16 mask and acknowledge combinations show the masking and the write-to-clear, and a tick that coincides with an acknowledge isolates the priority of expiry over clear.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  // tick source field width and code layout
  localparam int SRC_W    = 3;
  localparam int EXT_MAX  = 1;   // codes 0..EXT_MAX take the external tick
  localparam int INT_BASE = 4;   // first code of the internal tick enables

  // word-index map (byte address >> 2)
  localparam int CH_STRIDE = 4;
  localparam int OFS_DIV   = 0;
  localparam int OFS_DATA  = 1;
  localparam int OFS_CTRL  = 2;
  localparam int W_TIME    = 14;
  localparam int W_MASK    = 18;
  localparam int W_ACK     = 19;
  localparam int W_STAT    = 20;
  localparam int W_MSTAT   = 21;

  function automatic logic src_legal(input logic [SRC_W-1:0] code, input int nsrc);
    return (int'(code) <= EXT_MAX) ||
           ((int'(code) >= INT_BASE) && (int'(code) - INT_BASE < nsrc));
  endfunction

endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic             ctrl_wr,
  input  logic [31:0]      wdata,
  input  logic [NSRC-1:0]  tick_src,
  input  logic             ext_tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             run_q, run_d;

  op_e              wr_op;
  logic [SRC_W-1:0] wr_src;
  logic             ctrl_ok;
  logic             tick_sel;

  assign wr_op   = op_e'(wdata[1:0]);
  assign wr_src  = wdata[SRC_W+1:2];
  assign ctrl_ok = (wr_op != OP_BAD) && src_legal(wr_src, NSRC);

  // tick selection from the latched source code
  always_comb begin
    tick_sel = ext_tick;
    for (int i = 0; i < NSRC; i++) begin
      if (src_q == SRC_W'(INT_BASE + i)) tick_sel = tick_src[i];
    end
  end

  // next state
  always_comb begin
    div_d   = div_q;
    limit_d = limit_q;
    cnt_d   = cnt_q;
    src_d   = src_q;
    run_d   = run_q;
    expire  = 1'b0;
    if (div_wr) div_d = wdata[CNT_W-1:0];
    if (ctrl_wr && ctrl_ok) begin
      limit_d = div_q;
      src_d   = wr_src;
      case (wr_op)
        OP_LOAD: cnt_d = div_q;
        OP_HOLD: run_d = 1'b0;
        OP_RUN:  run_d = 1'b1;
        default: ;
      endcase
    end else if (run_q && tick_sel) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = limit_q;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      limit_q <= '0;
      cnt_q   <= '0;
      src_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (div_wr) div_q <= div_d;
      limit_q <= limit_d;
      cnt_q   <= cnt_d;
      src_q   <= src_d;
      run_q   <= run_d;
    end
  end

  assign count = cnt_q;

  // a stopped channel keeps its count unless software loads it
  assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctrl_wr) |=> $stable(cnt_q));

  // rejected control writes leave the configuration untouched
  assert_bad_ctrl_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[1:0] == 2'b11) |=> ($stable(run_q) && $stable(src_q) && $stable(limit_q)));

  // an expiry reloads the latched limit
  assert_reload_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(limit_q)));

endmodule

// File: rtl/dtmr_intc.sv
module dtmr_intc #(
  parameter int NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] expire,
  input  logic            mask_wr,
  input  logic            ack_wr,
  input  logic [NIRQ-1:0] wdata,
  output logic [NIRQ-1:0] status,
  output logic [NIRQ-1:0] mask,
  output logic            irq
);

  logic [NIRQ-1:0] status_q, status_d;
  logic [NIRQ-1:0] mask_q, mask_d;
  logic [NIRQ-1:0] clr;

  always_comb begin
    clr      = ack_wr ? wdata : '0;
    // set terms are applied after the clear, so a coincident expiry wins
    status_d = (status_q & ~clr) | expire;
    mask_d   = mask_wr ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      if (mask_wr) mask_q <= mask_d;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = |(status_q & mask_q);

  assert_expiry_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((status_q & $past(expire)) == $past(expire)));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((status_q & $past(wdata & ~expire)) == '0));

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NSRC   = 4,
  parameter int NTMR   = 2,
  parameter int TIME_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              ext_tick,
  output logic              irq
);

  localparam int WORD_W = ADDR_W - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              we;
  logic [TIME_W-1:0] time_q, time_d;
  logic [CNT_W-1:0]  cnt_all [NTMR];
  logic [NTMR-1:0]   expire;
  logic [NTMR-1:0]   status;
  logic [NTMR-1:0]   mask;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign we      = bus_sel && bus_wr && aligned;

  for (genvar g = 0; g < NTMR; g++) begin : g_ch
    logic div_wr, ctrl_wr;
    assign div_wr  = we && (word == WORD_W'(g * CH_STRIDE + OFS_DIV));
    assign ctrl_wr = we && (word == WORD_W'(g * CH_STRIDE + OFS_CTRL));

    dtmr_channel #(.CNT_W(CNT_W), .NSRC(NSRC)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .div_wr   (div_wr),
      .ctrl_wr  (ctrl_wr),
      .wdata    (bus_wdata),
      .tick_src (tick_src),
      .ext_tick (ext_tick),
      .count    (cnt_all[g]),
      .expire   (expire[g])
    );
  end

  dtmr_intc #(.NIRQ(NTMR)) u_intc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .expire  (expire),
    .mask_wr (we && (word == WORD_W'(W_MASK))),
    .ack_wr  (we && (word == WORD_W'(W_ACK))),
    .wdata   (bus_wdata[NTMR-1:0]),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  // free-running time base
  assign time_d = time_q + TIME_W'(1);
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) time_q <= '0;
    else            time_q <= time_d;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NTMR; i++) begin
        if (word == WORD_W'(i * CH_STRIDE + OFS_DATA)) bus_rdata = 32'(cnt_all[i]);
      end
      if (word == WORD_W'(W_TIME))  bus_rdata = 32'(time_q);
      if (word == WORD_W'(W_MASK))  bus_rdata = 32'(mask);
      if (word == WORD_W'(W_STAT))  bus_rdata = 32'(status);
      if (word == WORD_W'(W_MSTAT)) bus_rdata = 32'(status & mask);
    end
  end

  assert_time_step_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (time_q == $past(time_q) + TIME_W'(1)));

endmodule

// File: tb/dual_tick_timer_tb_top.sv
`timescale 1ns/1ps
module dual_tick_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic        ext_tick = 1'b0;
  logic        irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .ext_tick(ext_tick), .irq(irq)
  );

  localparam logic [6:0] A_DIV0 = 7'h00, A_DAT0 = 7'h04, A_CTL0 = 7'h08;
  localparam logic [6:0] A_DIV1 = 7'h10, A_DAT1 = 7'h14, A_CTL1 = 7'h18;
  localparam logic [6:0] A_TIME = 7'h38, A_MASK = 7'h48, A_ACK = 7'h4C;
  localparam logic [6:0] A_STAT = 7'h50, A_MSTAT = 7'h54;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic tick(input int line);
    if (line < 4) tick_src[line] = 1'b1; else ext_tick = 1'b1;
    @(negedge clk);
    tick_src = '0; ext_tick = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int src, input int op);
    return 32'((src << 2) | op);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t1, t2;
    int exp_cnt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdchk("R1 count0", A_DAT0, 0);
    rdchk("R1 count1", A_DAT1, 0);
    rdchk("R1 status", A_STAT, 0);
    rdchk("R1 mask", A_MASK, 0);
    rdchk("R1 masked", A_MSTAT, 0);
    chk("R1 irq", 32'(irq), 0);
    for (int l = 0; l < 5; l++) tick(l);
    rdchk("R1 stopped count0", A_DAT0, 0);
    rdchk("R1 stopped count1", A_DAT1, 0);

    // R2 / R12 divisor and load
    wr(A_DIV0, 32'h1234);
    rdchk("R2 divisor write no effect", A_DAT0, 0);
    wr(A_CTL0, ctl(4, 0));
    rdchk("R2 load ch0", A_DAT0, 32'h1234);
    rdchk("R12 ch1 untouched", A_DAT1, 0);
    wr(A_DIV1, 32'h55);
    wr(A_CTL1, ctl(4, 0));
    rdchk("R2 load ch1", A_DAT1, 32'h55);
    rdchk("R12 ch0 untouched", A_DAT0, 32'h1234);
    rdchk("R12 unmapped", 7'h20, 0);
    rdchk("R12 misaligned", 7'h05, 0);
    wr(7'h01, 32'h77);
    wr(7'h09, ctl(4, 0));
    rdchk("R12 misaligned write ignored", A_DAT0, 32'h1234);

    // R6 / R3 source sweep on channel 0
    for (int s = 0; s < 8; s++) begin
      if (s == 2 || s == 3) begin
        wr(A_DIV0, 10); wr(A_CTL0, ctl(4, 0)); wr(A_CTL0, ctl(4, 2));
        wr(A_DIV0, 3);
        wr(A_CTL0, ctl(s, 0));
        rdchk("R7 illegal source ignored", A_DAT0, 10);
        tick(0);
        rdchk("R7 illegal source keeps old source", A_DAT0, 9);
      end else begin
        wr(A_DIV0, 10); wr(A_CTL0, ctl(s, 0)); wr(A_CTL0, ctl(s, 2));
        exp_cnt = 10;
        for (int l = 0; l < 5; l++) begin
          tick(l);
          if ((s >= 4) ? (l == s - 4) : (l == 4)) exp_cnt--;
          rdchk($sformatf("R6 src %0d line %0d", s, l), A_DAT0, 32'(exp_cnt));
        end
        repeat (3) @(negedge clk);
        rdchk("R3 no tick no change", A_DAT0, 32'(exp_cnt));
      end
      wr(A_CTL0, ctl(4, 1));
    end

    // R7 illegal op, R5 hold
    wr(A_DIV0, 10); wr(A_CTL0, ctl(4, 0)); wr(A_CTL0, ctl(4, 2));
    tick(0);
    rdchk("R3 run decrement", A_DAT0, 9);
    wr(A_DIV0, 2);
    wr(A_CTL0, ctl(4, 3));
    rdchk("R7 op3 ignored", A_DAT0, 9);
    tick(0);
    rdchk("R7 op3 still running", A_DAT0, 8);
    wr(A_CTL0, ctl(4, 1));
    tick(0); tick(0);
    rdchk("R5 hold freezes", A_DAT0, 8);
    wr(A_CTL0, ctl(5, 3));
    tick(0); tick(1);
    rdchk("R7 op3 does not start", A_DAT0, 8);

    // R4 period sweep on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int d = 0; d < 6; d++) begin
        wr(ch ? A_CTL1 : A_CTL0, ctl(4 + ch, 1));
        wr(A_ACK, 3);
        wr(ch ? A_DIV1 : A_DIV0, d);
        wr(ch ? A_CTL1 : A_CTL0, ctl(4 + ch, 0));
        wr(ch ? A_CTL1 : A_CTL0, ctl(4 + ch, 2));
        for (int k = 1; k < d; k++) tick(ch);
        if (d >= 2) begin
          rdchk($sformatf("R4 ch%0d d%0d before expiry", ch, d), A_STAT, 0);
          rdchk($sformatf("R4 ch%0d d%0d count at 1", ch, d), ch ? A_DAT1 : A_DAT0, 1);
        end
        tick(ch);
        rdchk($sformatf("R4 ch%0d d%0d status", ch, d), A_STAT, 32'(1 << ch));
        rdchk($sformatf("R4 ch%0d d%0d reload", ch, d), ch ? A_DAT1 : A_DAT0, 32'(d));
      end
      wr(ch ? A_CTL1 : A_CTL0, ctl(4 + ch, 1));
    end

    // R8 / R9 mask and acknowledge sweep
    wr(A_ACK, 3);
    wr(A_DIV0, 1); wr(A_CTL0, ctl(4, 0)); wr(A_CTL0, ctl(4, 2));
    wr(A_DIV1, 1); wr(A_CTL1, ctl(5, 0)); wr(A_CTL1, ctl(5, 2));
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 4; a++) begin
        int e;
        wr(A_MASK, m);
        tick(0); tick(1);
        rdchk("R8 mask readback", A_MASK, 32'(m));
        rdchk("R8 masked full", A_MSTAT, 32'(m));
        chk("R8 irq full", 32'(irq), 32'(m != 0));
        wr(A_ACK, a);
        e = 3 & ~a;
        rdchk($sformatf("R9 ack %0d status", a), A_STAT, 32'(e));
        rdchk("R8 masked after ack", A_MSTAT, 32'(e & m));
        chk("R8 irq after ack", 32'(irq), 32'((e & m) != 0));
        tick(0);
        rdchk("R9 ack does not persist", A_STAT, 32'(e | 1));
      end
    end

    // R10 expiry versus acknowledge in the same cycle
    wr(A_ACK, 3);
    tick(1);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 3;
    tick_src[0] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_src = '0;
    rdchk("R10 expiry wins over ack", A_STAT, 1);

    // R11 time base
    rd(A_TIME, t1);
    repeat (37) @(negedge clk);
    rd(A_TIME, t2);
    chk("R11 time step 37", t2 - t1, 37);
    repeat (100) @(negedge clk);
    rd(A_TIME, v);
    chk("R11 time step 100", v - t2, 100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule